// File: doc/BRIEF.md
# Gray-Timestamp Hit Latency Buffer

This block holds the hits of one pixel until a fixed-latency first-level trigger decides whether to keep them. A shared timestamp generator counts up from zero to a programmable turnaround value `turn_n`. It holds that value for a second cycle and counts back down to zero. It holds zero for a second cycle and then repeats. The count is driven as an 8-bit Gray code, so every value in the range shows up exactly twice in each period of 2·turn_n+2 cycles.

The pixel owns two delay slots. When a hit strobe arrives, the first idle slot captures the current Gray timestamp. That capture counts as the first match. From then on the slot compares its stored code against the bus every cycle and counts the matches. The third match falls exactly 2·turn_n+2 cycles after the hit cycle. In that cycle the slot raises its expiry internally and releases itself. The pixel's coincidence output is the OR of the slot expiries, ANDed with the trigger input in that same cycle.

The hit input is a strobe with no back-pressure. There is no ready signal. A hit that finds both slots occupied is discarded, and `hit_drop` reports the discard in that same cycle. `turn_n` is expected to stay constant while the block runs, and a change takes effect cleanly only across a reset.

Top module: `gray_latency_pixel`

## Requirements
- R1: While reset is held, and in the first cycle after it is released with no hit applied, `busy` is 0, `coinc` is 0 and `hit_drop` is 0.
- R2: A hit in cycle c goes to slot 0 if slot 0 is idle, and otherwise to slot 1 if slot 1 is idle. The chosen slot's bit of `busy` (bit 0 = slot 0, bit 1 = slot 1) reads 1 from cycle c+1.
- R3: A hit in a cycle when both `busy` bits are 1 is discarded. `hit_drop` is 1 in that same cycle, and neither slot's occupancy or expiry cycle changes because of it.
- R4: A slot loaded by a hit in cycle c expires in cycle c+2·turn_n+2. If `trig` is 1 in that cycle, `coinc` is 1 in that cycle.
- R5: `coinc` is 0 in every cycle where no slot expires, whatever `trig` is. It is also 0 in an expiry cycle where `trig` is 0.
- R6: A slot's `busy` bit is 1 from the cycle after its hit up to and including its expiry cycle, and 0 in the cycle after it. A hit that arrives in the expiry cycle cannot use the expiring slot.
- R7: The latency of R4 is exact for any `turn_n` from 0 to 255 and for any position of the timestamp sequence at the hit. The timestamp code changes by at most one bit per cycle.
- R8: The two slots work independently. Two hits held at the same time each expire at their own hit cycle plus 2·turn_n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| turn_n | input | 8 | Turnaround value n of the timestamp sequence; latency is 2n+2 cycles |
| hit | input | 1 | Hit strobe, one cycle per hit |
| trig | input | 1 | Trigger, one cycle wide |
| coinc | output | 1 | Delayed hit coincident with the trigger |
| busy | output | 2 | Occupancy of each delay slot, bit i = slot i |
| hit_drop | output | 1 | Hit discarded because both slots were occupied |

## Verification
A new hit and a slot expiry can fall in the same cycle. So can a trigger and an expiry. The first case is provoked by a stream that strobes `hit` in every cycle. Both slots fill, and each later hit is discarded until an expiry. The hit in the expiry cycle must also be discarded, and the hit in the next cycle must land in the freed slot. The behavioural model decides both outcomes from the slot occupancy at the start of the cycle. The second case is provoked by raising `trig` in most expiry cycles and only rarely elsewhere. `coinc`, `busy` and `hit_drop` are compared with the model in every cycle, for several turnaround values including 0 and 255.

// File: rtl/glat_pkg.sv
package glat_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} sweep_dir_e;

  function automatic logic [7:0] to_gray8(input logic [7:0] b);
    return b ^ (b >> 1);
  endfunction
endpackage

// File: rtl/glat_timestamp.sv
module glat_timestamp #(
  parameter int TS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] turn_n,
  output logic [TS_W-1:0] ts_gray
);
  import glat_pkg::*;

  logic [TS_W-1:0] count_q;
  sweep_dir_e      dir_q;

  // Up to turn_n, hold once, down to zero, hold once: period 2n+2.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      dir_q   <= DIR_UP;
    end else begin
      unique case (dir_q)
        DIR_UP: begin
          if (count_q >= turn_n) dir_q <= DIR_DOWN;
          else                   count_q <= count_q + 1'b1;
        end
        DIR_DOWN: begin
          if (count_q == '0) dir_q <= DIR_UP;
          else               count_q <= count_q - 1'b1;
        end
        default: dir_q <= DIR_UP;
      endcase
    end
  end

  assign ts_gray = count_q ^ (count_q >> 1);
endmodule

// File: rtl/glat_slot.sv
module glat_slot #(
  parameter int TS_W    = 8,
  parameter int MATCHES = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [TS_W-1:0] ts_gray,
  output logic            busy,
  output logic            expire
);
  localparam int MW = $clog2(MATCHES);
  localparam logic [MW-1:0] LAST_SEEN = MW'(MATCHES - 1);

  logic [TS_W-1:0] stamp_q;
  logic [MW-1:0]   seen_q;
  logic            busy_q;
  logic            match;

  assign match  = busy_q && (stamp_q == ts_gray);
  assign expire = match && (seen_q == LAST_SEEN);
  assign busy   = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      stamp_q <= '0;
      seen_q  <= '0;
    end else if (load && !busy_q) begin
      busy_q  <= 1'b1;
      stamp_q <= ts_gray;
      seen_q  <= MW'(1);          // capture cycle is the first match
    end else if (expire) begin
      busy_q  <= 1'b0;
      seen_q  <= '0;
    end else if (match) begin
      seen_q  <= seen_q + 1'b1;
    end
  end
endmodule

// File: rtl/glat_alloc.sv
module glat_alloc #(
  parameter int NU = 2
) (
  input  logic          hit,
  input  logic [NU-1:0] busy,
  output logic [NU-1:0] grant,
  output logic          drop
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    grant = '0;
    for (int i = 0; i < NU; i++) begin
      if (hit && !busy[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
    drop = hit && !taken;
  end
endmodule

// File: rtl/gray_latency_pixel.sv
module gray_latency_pixel #(
  parameter int TS_W      = 8,
  parameter int NUM_UNITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TS_W-1:0]      turn_n,
  input  logic                 hit,
  input  logic                 trig,
  output logic                 coinc,
  output logic [NUM_UNITS-1:0] busy,
  output logic                 hit_drop
);
  logic [TS_W-1:0]      ts_gray;
  logic [NUM_UNITS-1:0] unit_grant;
  logic [NUM_UNITS-1:0] unit_expire;

  glat_timestamp #(.TS_W(TS_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .turn_n(turn_n), .ts_gray(ts_gray)
  );

  glat_alloc #(.NU(NUM_UNITS)) u_alloc (
    .hit(hit), .busy(busy), .grant(unit_grant), .drop(hit_drop)
  );

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_slot
    glat_slot #(.TS_W(TS_W), .MATCHES(3)) u_slot (
      .clk(clk), .rst_n(rst_n), .load(unit_grant[i]), .ts_gray(ts_gray),
      .busy(busy[i]), .expire(unit_expire[i])
    );
  end

  assign coinc = (|unit_expire) && trig;
endmodule

// File: rtl/gray_latency_checker.sv
module gray_latency_checker #(
  parameter int TS_W = 8,
  parameter int NU   = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hit,
  input logic            trig,
  input logic            coinc,
  input logic [NU-1:0]   busy,
  input logic            hit_drop,
  input logic [NU-1:0]   exp_v,
  input logic [TS_W-1:0] ts
);
  p_alloc_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !busy[0]) |=> busy[0]);

  p_drop_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_drop && !(|exp_v)) |=> (&busy));

  p_coinc_exp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    coinc |-> (|exp_v));

  p_coinc_trig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    coinc |-> trig);

  p_gray_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ts ^ $past(ts)) <= 1);

  for (genvar i = 0; i < NU; i++) begin : g_u
    p_free_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
      exp_v[i] |=> !busy[i]);
    p_exp_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      exp_v[i] |-> busy[i]);
    p_rise_by_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy[i]) |-> $past(hit));
  end
endmodule

bind gray_latency_pixel gray_latency_checker #(.TS_W(TS_W), .NU(NUM_UNITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit), .trig(trig), .coinc(coinc),
  .busy(busy), .hit_drop(hit_drop), .exp_v(unit_expire), .ts(ts_gray)
);

// File: tb/gray_latency_pixel_bench.sv
module gray_latency_pixel_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] turn_n = 8'd0;
  logic       hit = 1'b0;
  logic       trig = 1'b0;
  logic       coinc;
  logic [1:0] busy;
  logic       hit_drop;

  int checks = 0;
  int failures = 0;
  int cyc;
  bit mbusy [2];
  int mdue  [2];
  int coinc_seen;
  int coinc_want;

  always #10 clk = ~clk;

  gray_latency_pixel u_gray_latency_pixel (
    .clk(clk), .rst_n(rst_n), .turn_n(turn_n), .hit(hit), .trig(trig),
    .coinc(coinc), .busy(busy), .hit_drop(hit_drop)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s cycle=%0d n=%0d actual=%0d expected=%0d", tag, cyc, turn_n, act, exp);
    end
  endtask

  task automatic do_reset(input int n);
    @(negedge clk);
    rst_n = 1'b0; hit = 1'b0; trig = 1'b0; turn_n = 8'(n);
    repeat (3) @(negedge clk);
    #2;
    chk("R1 busy in reset", busy, 0);
    chk("R1 coinc in reset", coinc, 0);
    rst_n = 1'b1;
    cyc = 0;
    for (int i = 0; i < 2; i++) begin mbusy[i] = 1'b0; mdue[i] = -1; end
    coinc_seen = 0; coinc_want = 0;
  endtask

  // mode 0 sparse, 1 every cycle, 2 dense random, 3 two hits at cycles 2 and 5
  task automatic run(input int ncyc, input int mode);
    for (int k = 0; k < ncyc; k++) begin
      bit due_now, h, t, any_exp, all_busy;
      int lat;
      lat = 2 * int'(turn_n) + 2;
      if (k > 0 || cyc > 0) @(negedge clk);
      due_now = 1'b0;
      for (int i = 0; i < 2; i++) if (mbusy[i] && mdue[i] == cyc) due_now = 1'b1;
      case (mode)
        0: h = ($urandom % 40) == 0;
        1: h = 1'b1;
        2: h = ($urandom % 3) == 0;
        default: h = (cyc == 2) || (cyc == 5);
      endcase
      if (mode == 3) t = due_now;
      else t = due_now ? (($urandom % 4) != 0) : (($urandom % 16) == 0);
      hit = h; trig = t;
      #2;
      any_exp  = due_now;
      all_busy = mbusy[0] && mbusy[1];
      chk("R2 R6 busy", busy, {30'd0, mbusy[1], mbusy[0]});
      chk("R3 hit_drop", hit_drop, int'(h && all_busy));
      chk("R4 R5 coinc", coinc, int'(any_exp && t));
      if (coinc) coinc_seen++;
      if (any_exp && t) coinc_want++;
      // advance model to next cycle: free expiring slots, then place hit
      for (int i = 0; i < 2; i++) if (mbusy[i] && mdue[i] == cyc) mbusy[i] = 1'b0;
      if (h && !all_busy) begin
        if (!busy[0]) begin mbusy[0] = 1'b1; mdue[0] = cyc + lat; end
        else          begin mbusy[1] = 1'b1; mdue[1] = cyc + lat; end
      end
      cyc++;
    end
  endtask

  initial begin
    int ns [5] = '{0, 1, 3, 17, 255};
    for (int j = 0; j < 5; j++) begin
      int lat;
      lat = 2 * ns[j] + 2;
      do_reset(ns[j]);
      #2;
      chk("R1 busy after release", busy, 0);
      chk("R1 hit_drop after release", hit_drop, 0);
      // R8: two overlapping hits, each must meet its own trigger
      run(lat + 12, 3);
      chk("R8 both coincidences", coinc_seen, (lat > 3) ? 2 : 2);
      // R3 and R6: saturating hit stream
      run(2 * lat + 8, 1);
      run(4 * lat + 20, 0);
      // R7: arbitrary phases under dense random hits
      run(3 * lat + 30, 2);
      chk("R7 coincidences for this n", coinc_seen, coinc_want);
      @(negedge clk);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired at cycle=%0d", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule